// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Writer

This block stores received Ethernet frames into memory. Software builds a ring of five-word descriptors: header, buffer address, status word 1, status word 2 and next-descriptor address, at byte offsets 0, 4, 8, 12 and 16. It loads the address of the first descriptor and enables reception. The engine then fetches a descriptor that hardware owns and packs the incoming byte stream into 32-bit words in that descriptor's buffer. It writes the result into status word 2, hands the descriptor back by rewriting its header, and follows the next pointer.

Every transfer uses a single-beat memory port. A read returns its data in the same cycle as the request. The byte stream cannot be stalled. If a frame starts while the engine is not waiting with an owned descriptor, the whole frame is dropped and a drop pulse is raised. A counter of filled buffers rises once for each stored frame, and software lowers it one step at a time with a decrement strobe.

Top module: `rxq_dma_writer`

## Requirements
- R1: The engine reads the header at the ring pointer and uses the descriptor only when header bit 7 (hardware owns) is set. While that bit is clear it re-reads the header every cycle and writes nothing.
- R2: The bytes of a stored frame go to the buffer address in little-endian order, four bytes per word at consecutive word addresses. Unused lanes of the last word are written as zero.
- R3: Status word 2 is written with the stored byte count in bits 15:0, a good-receive flag in bit 23, a CRC-error flag in bit 20 (the inverse of the CRC-good input sampled with the last byte) and a length-error flag in bit 21.
- R4: The header write-back clears bit 7 and sets bit 31 (start of packet) and bit 30 (end of packet). It puts the stored byte count in bits 26:16 and keeps bits 29:27, 15:9 and 6:0.
- R5: If bit 9 (sticky) or bit 8 (next pointer valid) of the fetched header is clear, bit 8 is written back as zero. The engine then stops and is not busy until the ring pointer is loaded again.
- R6: After a write-back the engine continues at the address it read from offset 16 of the descriptor.
- R7: Status bits 23:16 hold a filled-buffer count. It rises by one per stored frame and falls by one per decrement strobe. It saturates at 0 and at 255, and an increment and a decrement in the same cycle leave it unchanged.
- R8: The buffer limit is the 7-bit size field times 16 bytes, and 96 (1536 bytes) is valid. Bytes beyond the limit are not written. Such a frame reports the truncated count, length error set and good receive clear.
- R9: A frame whose first byte arrives when the engine is not waiting with an owned descriptor causes no memory write. If reception is enabled, it raises the drop output for one cycle.
- R10: Status bit 7 (busy) is high in every state except idle and stopped. Clearing enable during a frame lets that frame complete, after which busy falls.
- R11: A load of the ring pointer takes effect only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load enable and size field |
| cfg_en | input | 1 | Receive enable value |
| cfg_bufsz | input | 7 | Buffer size in 16-byte units |
| cnt_dec | input | 1 | Decrement filled-buffer count |
| ptr_wr | input | 1 | Load ring pointer |
| ptr_wdata | input | 32 | Ring pointer byte address |
| stat_o | output | 32 | Bit 7 busy, bits 23:16 filled-buffer count |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_ok | input | 1 | CRC result, sampled with last byte |
| rx_drop | output | 1 | Frame dropped pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |

## Verification
After enable or ring-pointer load, the engine reaches the waiting state after three clock edges (header, buffer address, next pointer). The bench therefore waits six cycles before sending a frame. After the edge that takes a frame's last byte, the last data word is written in the next cycle, status word 2 in the cycle after, and the header and count at the third edge. Every memory and status check is made at a falling edge at least eight cycles after the last byte. A drop pulse appears the cycle after the first byte of the refused frame. A per-cycle monitor compares memory writes and drop pulses against the bench's model of when writes are allowed.

// File: rtl/rxq_dma_writer.sv
module rxq_dma_writer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_en,
  input  logic [6:0]  cfg_bufsz,
  input  logic        cnt_dec,
  input  logic        ptr_wr,
  input  logic [31:0] ptr_wdata,
  output logic [31:0] stat_o,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_crc_ok,
  output logic        rx_drop,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [31:0] HDR_KEEP = 32'h3800_FE7F;
  localparam logic [31:0] HDR_SEOP = 32'hC000_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_BUF, S_NXT, S_WAIT, S_RECV, S_DATA, S_STAT, S_WB, S_STOP
  } st_t;

  st_t         st;
  logic        en;
  logic [6:0]  bsz;
  logic [7:0]  bcnt;
  logic [31:0] cur, hdr, buf_a, nxt;
  logic [10:0] cnt;
  logic        trunc, crc_ok_q, in_frame;
  logic [31:0] wbuf, wr_addr, wr_data;
  logic        wr_pend;

  wire        busy    = (st != S_IDLE) && (st != S_STOP);
  wire [10:0] limit   = {bsz, 4'b0000};
  wire        sof     = rx_valid && !in_frame;
  wire        take    = rx_valid && ((st == S_RECV) || (st == S_WAIT && sof));
  wire        store   = take && (cnt < limit);
  wire        word_ok = store && ((cnt[1:0] == 2'd3) || rx_last);
  wire        next_ok = hdr[8] && hdr[9];
  wire        good    = crc_ok_q && !trunc;
  wire        inc     = (st == S_WB);
  wire [31:0] wmerge  = wbuf | ({24'd0, rx_data} << {cnt[1:0], 3'b000});
  wire [31:0] st2     = {8'd0, good, 1'b0, trunc, !crc_ok_q, 9'd0, cnt};
  wire [31:0] hdr_wb  = (hdr & HDR_KEEP) | HDR_SEOP | {5'd0, cnt, 16'd0} | {23'd0, next_ok, 8'd0};

  assign stat_o = {8'd0, bcnt, 8'd0, busy, 7'd0};

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = 32'd0; mem_wdata = 32'd0;
    case (st)
      S_HDR:  begin mem_req = 1'b1; mem_addr = cur; end
      S_BUF:  begin mem_req = 1'b1; mem_addr = cur + 32'd4; end
      S_NXT:  begin mem_req = 1'b1; mem_addr = cur + 32'd16; end
      S_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + 32'd12; mem_wdata = st2; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur; mem_wdata = hdr_wb; end
      default: if (wr_pend) begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr; mem_wdata = wr_data;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en <= 1'b0; bsz <= 7'd0; bcnt <= 8'd0;
      cur <= 32'd0; hdr <= 32'd0; buf_a <= 32'd0; nxt <= 32'd0;
      cnt <= 11'd0; trunc <= 1'b0; crc_ok_q <= 1'b0; in_frame <= 1'b0;
      wbuf <= 32'd0; wr_addr <= 32'd0; wr_data <= 32'd0; wr_pend <= 1'b0;
      rx_drop <= 1'b0;
    end else begin
      if (cfg_wr) begin
        en  <= cfg_en;
        bsz <= cfg_bufsz;
      end
      if (inc && !cnt_dec && bcnt != 8'hFF)      bcnt <= bcnt + 8'd1;
      else if (cnt_dec && !inc && bcnt != 8'd0) bcnt <= bcnt - 8'd1;
      if (rx_valid) in_frame <= !rx_last;
      rx_drop <= sof && !take && en;
      wr_pend <= 1'b0;

      case (st)
        S_IDLE: begin
          if (ptr_wr) cur <= ptr_wdata;
          if (en) st <= S_HDR;
        end
        S_STOP: if (ptr_wr) begin
          cur <= ptr_wdata;
          st  <= S_IDLE;
        end
        S_HDR: begin
          if (mem_rdata[7]) begin
            hdr <= mem_rdata;
            st  <= S_BUF;
          end else if (!en) st <= S_IDLE;
        end
        S_BUF: begin buf_a <= mem_rdata; st <= S_NXT; end
        S_NXT: begin
          nxt <= mem_rdata; cnt <= 11'd0; trunc <= 1'b0; wbuf <= 32'd0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (take)     st <= rx_last ? S_DATA : S_RECV;
          else if (!en) st <= S_IDLE;
        end
        S_RECV: if (take && rx_last) st <= S_DATA;
        S_DATA: st <= S_STAT;
        S_STAT: st <= S_WB;
        S_WB: begin
          cur <= nxt;
          st  <= !next_ok ? S_STOP : (en ? S_HDR : S_IDLE);
        end
        default: st <= S_IDLE;
      endcase

      if (take) begin
        if (rx_last) crc_ok_q <= rx_crc_ok;
        if (store) begin
          cnt  <= cnt + 11'd1;
          wbuf <= word_ok ? 32'd0 : wmerge;
          if (word_ok) begin
            wr_pend <= 1'b1;
            wr_addr <= buf_a + {21'd0, cnt[10:2], 2'b00};
            wr_data <= wmerge;
          end
        end else trunc <= 1'b1;
      end
    end
  end

  p_own_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUF) |-> $past(mem_rdata[7]));

  p_data_in_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (st == S_RECV || st == S_DATA)) |-> ((mem_addr - buf_a) < {21'd0, limit}));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != $past(bcnt)) |-> ((bcnt == $past(bcnt) + 8'd1) || (bcnt == $past(bcnt) - 8'd1)));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[7] |-> !mem_req);

  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && busy && st != S_WB) |=> (cur == $past(cur)));

  p_drop_nowait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> !$past(st == S_WAIT));
endmodule

// File: tb/rxq_dma_writer_tb.sv
module rxq_dma_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cnt_dec = 0, ptr_wr = 0;
  logic [6:0] cfg_bufsz = 0;
  logic [31:0] ptr_wdata = 0;
  logic [31:0] stat_o;
  logic rx_valid = 0, rx_last = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = 0;
  logic rx_drop, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  logic allow_wr = 1'b1;
  int tests = 0, fails = 0, drops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_dma_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_bufsz(cfg_bufsz),
    .cnt_dec(cnt_dec), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .stat_o(stat_o),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_ok(rx_crc_ok),
    .rx_drop(rx_drop), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      if (!allow_wr) begin
        fails++;
        $display("FAIL R9/R10 unexpected write addr %h act %h exp none", mem_addr, mem_wdata);
      end
    end
    if (rx_drop) drops++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(logic en, logic [6:0] sz);
    @(negedge clk); cfg_wr = 1; cfg_en = en; cfg_bufsz = sz;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic load_ptr(logic [31:0] a);
    @(negedge clk); ptr_wr = 1; ptr_wdata = a;
    @(negedge clk); ptr_wr = 0;
  endtask

  task automatic dec_count(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_dec = 1;
      @(negedge clk); cnt_dec = 0;
    end
  endtask

  // stop_at >= 0 clears enable while that byte is driven
  task automatic send(int len, logic [7:0] seed, logic ok, int stop_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = seed + 8'(i); rx_last = (i == len - 1); rx_crc_ok = ok;
      cfg_wr = (i == stop_at); cfg_en = 0;
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; cfg_wr = 0;
    wait_cyc(8);
  endtask

  function automatic logic [31:0] word_of(logic [7:0] seed, int len, int k);
    logic [31:0] w = 0;
    for (int b = 0; b < 4; b++)
      if (4*k + b < len) w[8*b +: 8] = seed + 8'(4*k + b);
    return w;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act running exp done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEADBEEF;
    mem[0]  = 32'h380; mem[1]  = 32'h100; mem[2]  = 0; mem[3]  = 0; mem[4]  = 32'h20;
    mem[8]  = 32'h380; mem[9]  = 32'h200; mem[10] = 0; mem[11] = 0; mem[12] = 32'h40;
    mem[16] = 32'h180; mem[17] = 32'h300; mem[18] = 0; mem[19] = 0; mem[20] = 32'h00;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    check("R10 reset status", stat_o, 32'h0);
    check("R9 reset drop", {31'd0, rx_drop}, 32'h0);

    load_ptr(32'h0);
    set_cfg(1, 7'd96);
    wait_cyc(6);
    check("R10 busy while waiting", {31'd0, stat_o[7]}, 32'h1);

    // frame A: 6 bytes, good, 1536-byte buffer
    send(6, 8'h10, 1, -1);
    check("R4 header A", mem[0], 32'hC006_0300);
    check("R3 status A", mem[3], 32'h0080_0006);
    check("R2 data A w0", mem[64], word_of(8'h10, 6, 0));
    check("R2 data A w1 zero lanes", mem[65], word_of(8'h10, 6, 1));
    check("R7 count after A", {24'd0, stat_o[23:16]}, 32'd1);

    // frame B: 40 bytes into a 32-byte buffer, bad CRC
    set_cfg(1, 7'd2);
    send(40, 8'h40, 0, -1);
    check("R6 header B at next", mem[8], 32'hC020_0300);
    check("R8 status B truncated", mem[11], 32'h0030_0020);
    check("R8 last stored word", mem[128 + 7], word_of(8'h40, 40, 7));
    check("R8 beyond limit untouched", mem[128 + 8], 32'hDEADBEEF);
    check("R7 count after B", {24'd0, stat_o[23:16]}, 32'd2);
    dec_count(1);
    check("R7 count after decrement", {24'd0, stat_o[23:16]}, 32'd1);

    // frame C: sticky clear, ring stops
    set_cfg(1, 7'd96);
    send(5, 8'h70, 1, -1);
    check("R5 header C next-valid cleared", mem[16], 32'hC005_0000);
    check("R3 status C", mem[19], 32'h0080_0005);
    check("R2 data C w1", mem[193], word_of(8'h70, 5, 1));
    check("R5 stopped not busy", {31'd0, stat_o[7]}, 32'h0);
    check("R7 count after C", {24'd0, stat_o[23:16]}, 32'd2);

    // frame D while stopped
    allow_wr = 0;
    send(3, 8'h90, 1, -1);
    allow_wr = 1;
    check("R9 drop while stopped", drops, 32'd1);

    // reload to software-owned descriptor: polling
    load_ptr(32'h20);
    wait_cyc(4);
    check("R1 polling is busy", {31'd0, stat_o[7]}, 32'h1);
    send(3, 8'h95, 1, -1);
    check("R9 drop while polling", drops, 32'd2);
    check("R1 sw-owned header untouched", mem[8], 32'hC020_0300);
    mem[8] = 32'h380; mem[16] = 32'h380;
    wait_cyc(6);

    // frame F into desc1
    send(4, 8'hA0, 1, -1);
    check("R4 header F", mem[8], 32'hC004_0300);
    check("R3 status F", mem[11], 32'h0080_0004);
    check("R2 data F", mem[128], word_of(8'hA0, 4, 0));

    // frame G: enable cleared mid-frame, still completes
    wait_cyc(2);
    send(10, 8'hB0, 1, 5);
    check("R10 status G completed", mem[19], 32'h0080_000A);
    check("R2 data G tail", mem[194], word_of(8'hB0, 10, 2));
    check("R10 idle after disable", {31'd0, stat_o[7]}, 32'h0);
    check("R7 count after G", {24'd0, stat_o[23:16]}, 32'd4);

    // disabled: frame ignored, no drop pulse
    allow_wr = 0;
    send(4, 8'hD0, 1, -1);
    allow_wr = 1;
    check("R9 no drop when disabled", drops, 32'd2);

    // re-enable: pointer at desc0 (sw owned); pointer load while busy ignored
    set_cfg(1, 7'd96);
    wait_cyc(3);
    load_ptr(32'h40);
    mem[0] = 32'h380;
    wait_cyc(6);
    send(37, 8'hC0, 1, -1);
    check("R11 frame H in desc0", mem[3], 32'h0080_0025);
    check("R11 desc2 status unchanged", mem[19], 32'h0080_000A);
    check("R4 header H", mem[0], 32'hC025_0300);
    check("R8 1536 buffer no truncation", mem[64 + 9], word_of(8'hC0, 37, 9));
    check("R7 count after H", {24'd0, stat_o[23:16]}, 32'd5);

    dec_count(7);
    check("R7 count saturates at zero", {24'd0, stat_o[23:16]}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule